// File: doc/BRIEF.md
# Accelerator Core Run Control

This block sits between a host and a small embedded processor core and decides when that core may run. The host reaches it through a simple 32-bit register bus with word addresses. Through that bus the host sets, clears and enables four interrupt sources. It also writes a run-control register with two independent bits: one freezes the core and one holds it in software reset. The block turns these writes into three outputs: a halt level, a one-cycle core reset pulse, and a registered start program counter.

The core reports two events back to the block as single-cycle pulses. A completion pause tells the host that the work is done and parks the core in freeze plus software reset. A breakpoint also parks the core, but in freeze only, and it flags an instruction fault. Both events raise pending interrupt bits. Each bit reaches its host interrupt line only while the matching enable bit is set.

Word map, taking the address modulo the 0x1000-byte window: 0x00 is the pending state, 0x04 the enable mask, 0x08 the test register and 0x0C the run-control register. Any other word reads as zero, and writes to it are dropped.

Top module: `core_run_ctrl`

## Requirements
- R1: After reset, core_halt is 1 and core_rst_pulse is 0. Reading 0x0C returns 3 (freeze and software reset). Reading 0x00 and 0x04 returns 0, and all four interrupt lines are 0.
- R2: A write to 0x00 clears every pending bit whose data bit is 1 and leaves the other pending bits alone. A read of 0x00 returns the pending bits in [3:0].
- R3: A write to 0x08 sets every pending bit whose data bit is 1, taking data bits [3:0] only. A read of 0x08 returns 0.
- R4: Pending and enable bits map as follows: bit 0 is host request, bit 1 is finish, bit 2 is instruction fault and bit 3 is data fault. Each interrupt line is its pending bit ANDed with its enable bit. The enable mask is written at 0x04, and reads of 0x04 return it.
- R5: In a write to 0x0C, bit 0 is freeze, bit 1 is software reset and bits [23:2] are the start offset. A read of 0x0C returns the current mode in [1:0], with zero in every bit above.
- R6: A control write that takes the mode from run (both bits 0) to any other value sets core_halt.
- R7: A control write that takes software reset from 1 to 0 raises core_rst_pulse for exactly one cycle. The same write loads core_start_pc with the offset field plus MEM_BASE. core_start_pc changes only with such a pulse.
- R8: core_halt clears only when the mode becomes run, and it is 1 in every non-run mode.
- R9: A completion pause event sets core_halt, sets the mode to 3 and sets the finish pending bit.
- R10: A breakpoint event sets core_halt, sets the mode to 1 (freeze only) and sets both the finish and the instruction-fault pending bits.
- R11: An event overrides a control write made in the same cycle. A completion pause overrides a breakpoint for the mode. An event or a test-register set overrides a same-cycle clear of the same pending bit.
- R12: The effects of a write or an event appear at the outputs in the cycle after the clock edge that samples them. Read data appears in the cycle after the edge that samples the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request, sampled on the rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| ev_pause | input | 1 | Completion pause event pulse from the core |
| ev_break | input | 1 | Breakpoint event pulse from the core |
| core_halt | output | 1 | Holds the core stopped |
| core_rst_pulse | output | 1 | One-cycle core reset request |
| core_start_pc | output | PC_W | Program counter the core starts from after reset |
| irq_host_req | output | 1 | Host request interrupt |
| irq_finish | output | 1 | Finish interrupt |
| irq_ifault | output | 1 | Instruction fault interrupt |
| irq_dfault | output | 1 | Data fault interrupt |

## Verification
Every result of this block comes out of a single register stage. The mode, halt, start PC, pending bits and interrupt lines all take their new values at the edge that samples the write or event. They are therefore due in the next low clock phase. The reset pulse exists only in that cycle and must be gone one cycle later. Read data is due one cycle after the sampled request. The bench drives stimulus on falling edges, waits exactly one rising edge and samples on the following falling edge. It samples the pulse at that point, then checks that the pulse has dropped one cycle later.

// File: rtl/crc_pkg.sv
package crc_pkg;
   localparam int unsigned IRQ_N = 4;

   // interrupt bit positions (visible to software)
   localparam int unsigned IRQ_HOST_REQ = 0;
   localparam int unsigned IRQ_FINISH   = 1;
   localparam int unsigned IRQ_IFAULT   = 2;
   localparam int unsigned IRQ_DFAULT   = 3;

   // word indices inside the register window
   localparam int unsigned WORD_STATE  = 0;
   localparam int unsigned WORD_ENABLE = 1;
   localparam int unsigned WORD_TEST   = 2;
   localparam int unsigned WORD_CTRL   = 3;

   // run mode: bit 1 software reset, bit 0 freeze
   typedef struct packed {
      logic swrst;
      logic freeze;
   } mode_t;

   localparam mode_t MODE_RUN    = '{swrst: 1'b0, freeze: 1'b0};
   localparam mode_t MODE_FREEZE = '{swrst: 1'b0, freeze: 1'b1};
   localparam mode_t MODE_PARKED = '{swrst: 1'b1, freeze: 1'b1};

   typedef struct packed {
      logic state_clr;
      logic enable_wr;
      logic test_set;
      logic ctrl_wr;
   } wr_strobe_t;
endpackage

// File: rtl/crc_regif.sv
module crc_regif
   import crc_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [IRQ_N-1:0]  pend,
   input  logic [IRQ_N-1:0]  en,
   input  mode_t             mode,
   output wr_strobe_t        strobe,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("crc_regif: ADDR_W must cover four words");
      end
      if (DATA_W < IRQ_N + 2) begin : g_bad_data
         $error("crc_regif: DATA_W too narrow");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              wr_go, rd_go;
   logic [DATA_W-1:0] rd_mux;
   logic [1:0]        unused_byte_lanes;

   assign word              = bus_addr[ADDR_W-1:2];
   assign unused_byte_lanes = bus_addr[1:0];
   assign wr_go             = bus_req &  bus_we;
   assign rd_go             = bus_req & ~bus_we;

   always_comb begin
      strobe.state_clr = wr_go && (word == WORD_W'(WORD_STATE));
      strobe.enable_wr = wr_go && (word == WORD_W'(WORD_ENABLE));
      strobe.test_set  = wr_go && (word == WORD_W'(WORD_TEST));
      strobe.ctrl_wr   = wr_go && (word == WORD_W'(WORD_CTRL));
   end

   always_comb begin
      rd_mux = '0;
      if (word == WORD_W'(WORD_STATE))       rd_mux[IRQ_N-1:0] = pend;
      else if (word == WORD_W'(WORD_ENABLE)) rd_mux[IRQ_N-1:0] = en;
      else if (word == WORD_W'(WORD_CTRL))   rd_mux[1:0]       = mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_go) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/crc_irq.sv
module crc_irq
   import crc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  wr_strobe_t       strobe,
   input  logic [IRQ_N-1:0] wmask,
   input  logic [IRQ_N-1:0] ev_set,
   output logic [IRQ_N-1:0] pend,
   output logic [IRQ_N-1:0] en,
   output logic [IRQ_N-1:0] irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                en <= '0;
      else if (strobe.enable_wr) en <= wmask;
   end

   generate
      for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
         logic clr_i, set_i;
         assign clr_i = strobe.state_clr & wmask[i];
         assign set_i = (strobe.test_set & wmask[i]) | ev_set[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= set_i | (pend[i] & ~clr_i);
         end
         assign irq[i] = pend[i] & en[i];
      end
   endgenerate
endmodule

// File: rtl/crc_runctl.sv
module crc_runctl
   import crc_pkg::*;
#(
   parameter int unsigned         OFS_W    = 22,
   parameter int unsigned         PC_W     = 32,
   parameter logic [PC_W-1:0]     MEM_BASE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [OFS_W+1:0] ctrl_data,
   input  logic             ev_pause,
   input  logic             ev_break,
   output mode_t            mode,
   output logic             halt,
   output logic             rst_pulse,
   output logic [PC_W-1:0]  start_pc,
   output logic [IRQ_N-1:0] ev_set
);
   generate
      if (PC_W < OFS_W) begin : g_bad_pc
         $error("crc_runctl: PC_W narrower than the offset field");
      end
   endgenerate

   mode_t           wr_mode, nxt_mode;
   logic            nxt_halt, nxt_pulse, load_pc;
   logic [PC_W-1:0] new_pc;

   assign wr_mode = mode_t'(ctrl_data[1:0]);
   assign new_pc  = PC_W'(ctrl_data[OFS_W+1:2]) + MEM_BASE;

   always_comb begin
      nxt_mode  = mode;
      nxt_halt  = halt;
      nxt_pulse = 1'b0;
      load_pc   = 1'b0;
      if (ev_pause) begin
         nxt_mode = MODE_PARKED;
         nxt_halt = 1'b1;
      end else if (ev_break) begin
         nxt_mode = MODE_FREEZE;
         nxt_halt = 1'b1;
      end else if (ctrl_wr) begin
         if (mode == MODE_RUN && wr_mode != MODE_RUN) nxt_halt = 1'b1;
         if (mode != MODE_RUN && wr_mode == MODE_RUN) nxt_halt = 1'b0;
         if (mode.swrst && !wr_mode.swrst) begin
            nxt_pulse = 1'b1;
            load_pc   = 1'b1;
         end
         nxt_mode = wr_mode;
      end
   end

   always_comb begin
      ev_set             = '0;
      ev_set[IRQ_FINISH] = ev_pause | ev_break;
      ev_set[IRQ_IFAULT] = ev_break;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= MODE_PARKED;
         halt      <= 1'b1;
         rst_pulse <= 1'b0;
         start_pc  <= MEM_BASE;
      end else begin
         mode      <= nxt_mode;
         halt      <= nxt_halt;
         rst_pulse <= nxt_pulse;
         if (load_pc) start_pc <= new_pc;
      end
   end
endmodule

// File: rtl/core_run_ctrl.sv
module core_run_ctrl
   import crc_pkg::*;
#(
   parameter int unsigned     ADDR_W   = 12,
   parameter int unsigned     DATA_W   = 32,
   parameter int unsigned     OFS_W    = 22,
   parameter int unsigned     PC_W     = 32,
   parameter logic [PC_W-1:0] MEM_BASE = 32'h0001_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_pause,
   input  logic              ev_break,
   output logic              core_halt,
   output logic              core_rst_pulse,
   output logic [PC_W-1:0]   core_start_pc,
   output logic              irq_host_req,
   output logic              irq_finish,
   output logic              irq_ifault,
   output logic              irq_dfault
);
   generate
      if (DATA_W <= OFS_W + 2) begin : g_bad_ctrl
         $error("core_run_ctrl: DATA_W must exceed the control field");
      end
   endgenerate

   wr_strobe_t       strobe;
   mode_t            mode_w;
   logic [IRQ_N-1:0] pend_w, en_w, irq_w, ev_set_w;
   logic             unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:OFS_W+2];

   crc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .pend      (pend_w),
      .en        (en_w),
      .mode      (mode_w),
      .strobe    (strobe),
      .bus_rdata (bus_rdata)
   );

   crc_irq i_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe),
      .wmask  (bus_wdata[IRQ_N-1:0]),
      .ev_set (ev_set_w),
      .pend   (pend_w),
      .en     (en_w),
      .irq    (irq_w)
   );

   crc_runctl #(.OFS_W(OFS_W), .PC_W(PC_W), .MEM_BASE(MEM_BASE)) i_runctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (strobe.ctrl_wr),
      .ctrl_data (bus_wdata[OFS_W+1:0]),
      .ev_pause  (ev_pause),
      .ev_break  (ev_break),
      .mode      (mode_w),
      .halt      (core_halt),
      .rst_pulse (core_rst_pulse),
      .start_pc  (core_start_pc),
      .ev_set    (ev_set_w)
   );

   assign irq_host_req = irq_w[IRQ_HOST_REQ];
   assign irq_finish   = irq_w[IRQ_FINISH];
   assign irq_ifault   = irq_w[IRQ_IFAULT];
   assign irq_dfault   = irq_w[IRQ_DFAULT];
endmodule

// File: rtl/crc_checker.sv
module crc_checker #(
   parameter int unsigned PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ev_pause,
   input logic            ev_break,
   input logic [1:0]      mode,
   input logic            halt,
   input logic            rst_pulse,
   input logic [PC_W-1:0] start_pc,
   input logic            pend_fin,
   input logic            pend_ifault,
   input logic [3:0]      en,
   input logic [3:0]      irq
);
   a_r8_halt_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
      halt == (mode != 2'b00));

   a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> (!mode[1] && $past(mode[1])));

   a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_pulse |-> $stable(start_pc));

   a_r9_pause_parks: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pause |=> (mode == 2'b11 && halt && pend_fin));

   a_r10_break_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_break && !ev_pause) |=> (mode == 2'b01 && halt && pend_fin && pend_ifault));

   a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~en) == 4'b0000);
endmodule

bind core_run_ctrl crc_checker #(.PC_W(PC_W)) i_crc_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev_pause    (ev_pause),
   .ev_break    (ev_break),
   .mode        (mode_w),
   .halt        (core_halt),
   .rst_pulse   (core_rst_pulse),
   .start_pc    (core_start_pc),
   .pend_fin    (pend_w[1]),
   .pend_ifault (pend_w[2]),
   .en          (en_w),
   .irq         (irq_w)
);

// File: tb/test_core_run_ctrl.sv
module test_core_run_ctrl;
   localparam int          ADDR_W = 12;
   localparam int          DATA_W = 32;
   localparam int          PC_W   = 32;
   localparam logic [31:0] BASE   = 32'h0001_0000;
   localparam time         TCLK   = 5ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_req = 1'b0, bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              ev_pause = 1'b0, ev_break = 1'b0;
   logic              core_halt, core_rst_pulse;
   logic [PC_W-1:0]   core_start_pc;
   logic              irq_host_req, irq_finish, irq_ifault, irq_dfault;

   int total = 0;
   int bad = 0;
   bit ended = 0;

   always #(TCLK/2) clk = ~clk;

   core_run_ctrl i_core_run_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_pause(ev_pause), .ev_break(ev_break), .core_halt(core_halt),
      .core_rst_pulse(core_rst_pulse), .core_start_pc(core_start_pc),
      .irq_host_req(irq_host_req), .irq_finish(irq_finish),
      .irq_ifault(irq_ifault), .irq_dfault(irq_dfault)
   );

   function automatic logic [3:0] irqs();
      return {irq_dfault, irq_ifault, irq_finish, irq_host_req};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      step();
      bus_req = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 halt", 32'(core_halt), 32'd1);
      check("R1 pulse", 32'(core_rst_pulse), 32'd0);
      check("R1 irq lines", 32'(irqs()), 32'd0);
      rd(12'h00C, v); check("R1 mode", v, 32'd3);
      rd(12'h000, v); check("R1 pending", v, 32'd0);
      rd(12'h004, v); check("R1 enable", v, 32'd0);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(12'h008, 32'hFFFF_FFFF);
      rd(12'h000, v); check("R3 test sets only 4 bits", v, 32'hF);
      check("R4 all masked", 32'(irqs()), 32'd0);
      rd(12'h008, v); check("R3 test reads zero", v, 32'd0);
      wr(12'h004, 32'h5);
      check("R4 lines after enable", 32'(irqs()), 32'h5);
      rd(12'h004, v); check("R4 enable readback", v, 32'h5);
      wr(12'h000, 32'h1);
      rd(12'h000, v); check("R2 clear one bit", v, 32'hE);
      check("R4 host line drops", 32'(irqs()), 32'h4);
      wr(12'h000, 32'hF);
      rd(12'h000, v); check("R2 clear rest", v, 32'h0);
      wr(12'h010, 32'hF);
      rd(12'h000, v); check("R3 unmapped write ignored", v, 32'h0);
   endtask

   task automatic t_runctl();
      logic [31:0] v;
      wr(12'h00C, (32'h1234 << 2) | 32'h1);
      check("R7 pulse on swrst fall", 32'(core_rst_pulse), 32'd1);
      check("R7 start pc", core_start_pc, 32'h1234 + BASE);
      check("R8 still halted in freeze", 32'(core_halt), 32'd1);
      step();
      check("R7 pulse one cycle", 32'(core_rst_pulse), 32'd0);
      rd(12'h00C, v); check("R5 mode only", v, 32'd1);
      wr(12'h00C, 32'h0);
      check("R8 run releases halt", 32'(core_halt), 32'd0);
      check("R7 no pulse without swrst fall", 32'(core_rst_pulse), 32'd0);
      wr(12'h00C, 32'h2 | (32'h77 << 2));
      check("R6 leave run halts", 32'(core_halt), 32'd1);
      check("R7 pc unchanged", core_start_pc, 32'h1234 + BASE);
      wr(12'h00C, 32'h55 << 2);
      check("R7 second pulse", 32'(core_rst_pulse), 32'd1);
      check("R7 second pc", core_start_pc, 32'h55 + BASE);
      check("R8 run again", 32'(core_halt), 32'd0);
      step();
   endtask

   task automatic t_pause();
      logic [31:0] v;
      wr(12'h004, 32'hF);
      ev_pause = 1'b1; step(); ev_pause = 1'b0;
      check("R9 halt", 32'(core_halt), 32'd1);
      check("R12 R9 finish line next cycle", 32'(irqs()), 32'h2);
      rd(12'h00C, v); check("R9 mode parked", v, 32'd3);
      rd(12'h000, v); check("R9 pending", v, 32'h2);
   endtask

   task automatic t_break();
      logic [31:0] v;
      wr(12'h000, 32'hF);
      wr(12'h00C, 32'h0);
      check("R8 run after pause", 32'(core_halt), 32'd0);
      ev_break = 1'b1; step(); ev_break = 1'b0;
      check("R10 halt", 32'(core_halt), 32'd1);
      check("R10 lines", 32'(irqs()), 32'h6);
      rd(12'h00C, v); check("R10 mode freeze", v, 32'd1);
      wr(12'h00C, 32'h0);
      check("R10 R7 resume without pulse", 32'(core_rst_pulse), 32'd0);
      check("R8 resume", 32'(core_halt), 32'd0);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      wr(12'h000, 32'hF);
      ev_pause = 1'b1;
      wr(12'h00C, 32'h0);
      ev_pause = 1'b0;
      check("R11 pause beats write halt", 32'(core_halt), 32'd1);
      rd(12'h00C, v); check("R11 pause beats write mode", v, 32'd3);
      ev_break = 1'b1;
      wr(12'h000, 32'h2);
      ev_break = 1'b0;
      rd(12'h000, v); check("R11 set beats clear", v, 32'h6);
      rd(12'h00C, v); check("R11 break mode", v, 32'd1);
      ev_pause = 1'b1; ev_break = 1'b1; step();
      ev_pause = 1'b0; ev_break = 1'b0;
      rd(12'h00C, v); check("R11 pause beats break", v, 32'd3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_irq();
      t_runctl();
      t_pause();
      t_break();
      t_priority();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(TCLK * 20000);
      if (!ended) begin
         ended = 1;
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule